// File: doc/BRIEF.md
# Running Square Counter

This block holds a counter value and, beside it, the square of that value. Each increment request moves the counter up by one and brings the square up to date without a multiplier. The update uses the identity that the square of a value equals the previous square plus the previous value plus the new value. One adder, sized to the square, is used twice per update. In the cycle the request is accepted, the old counter value is added into the square while the counter steps up. In the following cycle the new counter value is added in.

The consumer sees a single `ready` signal. While it is high the two outputs agree (`square_o == count_o * count_o`) and a request is accepted. It stays low for exactly one cycle after each acceptance, and requests in that cycle are ignored. When the counter wraps from its largest value back to zero, the square is cleared with it and a sticky wrap flag is raised. The flag stays up until reset. An adder variant parameter selects a behavioural adder or an explicit ripple-carry chain.

Top module: `run_square_counter`

## Requirements
- R1: A synchronous reset, sampled high at a rising clock edge, leaves count_o = 0, square_o = 0, wrap_o = 0 and ready_o = 1 after that edge.
- R2: With ready_o high, inc_req_i high at a rising edge is accepted, and count_o shows the old value plus one directly after that edge.
- R3: Directly after an accepting edge that does not wrap, square_o equals the old square plus the old count.
- R4: ready_o is low for exactly the one cycle after an accepting edge. inc_req_i held high during that cycle is ignored: count_o is unchanged when ready_o returns.
- R5: Whenever ready_o is high, square_o equals count_o multiplied by count_o (2*CNT_W bits wide).
- R6: With ready_o high and inc_req_i low at an edge, count_o and square_o keep their values.
- R7: An accepted request with count_o at 2^CNT_W-1 leaves count_o = 0 and square_o = 0 and sets wrap_o. wrap_o then stays 1 until reset.
- R8: After a wrap, further requests count up from zero, and R5 keeps holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_req_i | input | 1 | Increment request, taken when ready_o is high |
| ready_o | output | 1 | High when idle; the outputs are consistent |
| count_o | output | CNT_W | Counter value n |
| square_o | output | 2*CNT_W | Running value n squared |
| wrap_o | output | 1 | Sticky flag, set when the counter wraps to zero |

## Verification
A corrupted square register stays corrupted, because every later update adds onto it. The error therefore shows on square_o at the next cycle in which ready_o is high, and at every idle cycle after that. A counter that misses or doubles a step shows on count_o directly after the accepting edge. It also breaks the square relation one cycle later. A handshake fault shows within two cycles, either as ready_o staying low or as an extra step when a request is held through the busy cycle.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
   typedef enum logic [0:0] {
      SQC_IDLE   = 1'b0,
      SQC_SETTLE = 1'b1
   } sqc_state_e;
endpackage

// File: rtl/sqc_adder.sv
module sqc_adder #(
   parameter int SUM_W      = 16,
   parameter bit USE_RIPPLE = 1'b1
) (
   input  logic [SUM_W-1:0] a_i,
   input  logic [SUM_W-1:0] b_i,
   output logic [SUM_W-1:0] sum_o
);
   if (SUM_W < 2) begin : g_bad_width
      $error("sqc_adder: SUM_W must be at least 2");
   end

   if (USE_RIPPLE) begin : g_ripple
      logic [SUM_W-1:0] carry;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < SUM_W; i++) begin : g_bit
         assign sum_o[i] = a_i[i] ^ b_i[i] ^ carry[i];
         if (i < SUM_W - 1) begin : g_carry
            assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
         end
      end
   end else begin : g_behav
      assign sum_o = a_i + b_i;
   end
endmodule

// File: rtl/sqc_ctrl.sv
module sqc_ctrl
   import sqc_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic inc_req_i,
   output logic ready_o,
   output logic accept_o,
   output logic settle_o
);
   sqc_state_e state_q;

   assign ready_o  = (state_q == SQC_IDLE);
   assign accept_o = ready_o & inc_req_i;
   assign settle_o = (state_q == SQC_SETTLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SQC_IDLE;
      end else if (accept_o) begin
         state_q <= SQC_SETTLE;
      end else begin
         state_q <= SQC_IDLE;
      end
   end

   // R4: busy for exactly one cycle after each acceptance
   a_r4_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
      accept_o |=> (!ready_o ##1 ready_o));
endmodule

// File: rtl/sqc_counter.sv
module sqc_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_i,
   output logic [CNT_W-1:0] count_o,
   output logic             at_max_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

   assign at_max_o = (count_o == MAX_VAL);

   always_ff @(posedge clk) begin
      if (rst) begin
         count_o <= '0;
         wrap_o  <= 1'b0;
      end else if (step_i) begin
         count_o <= count_o + 1'b1;
         if (at_max_o) begin
            wrap_o <= 1'b1;
         end
      end
   end

   // R2: each accepted step moves the count by exactly one
   a_r2_step: assert property (@(posedge clk) disable iff (rst)
      (step_i && !at_max_o) |=> (count_o == $past(count_o) + 1'b1));
   // R7: a wrap returns to zero and raises the flag
   a_r7_wrap_zero: assert property (@(posedge clk) disable iff (rst)
      (step_i && at_max_o) |=> (count_o == '0 && wrap_o));
   // R7: the flag is sticky
   a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      wrap_o |=> wrap_o);
endmodule

// File: rtl/run_square_counter.sv
module run_square_counter #(
   parameter int CNT_W      = 8,
   parameter bit USE_RIPPLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               inc_req_i,
   output logic               ready_o,
   output logic [CNT_W-1:0]   count_o,
   output logic [2*CNT_W-1:0] square_o,
   output logic               wrap_o
);
   localparam int SQ_W = 2 * CNT_W;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("run_square_counter: CNT_W must lie in 2..32");
   end

   logic            accept;
   logic            settle;
   logic            at_max;
   logic [SQ_W-1:0] count_ext;
   logic [SQ_W-1:0] sum;
   logic [SQ_W-1:0] square_q;

   sqc_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .inc_req_i(inc_req_i),
      .ready_o  (ready_o),
      .accept_o (accept),
      .settle_o (settle)
   );

   sqc_counter #(.CNT_W(CNT_W)) u_counter (
      .clk     (clk),
      .rst     (rst),
      .step_i  (accept),
      .count_o (count_o),
      .at_max_o(at_max),
      .wrap_o  (wrap_o)
   );

   // Shared adder: the square plus whatever count is held this cycle
   // (old n in the accepting cycle, new n in the settle cycle).
   assign count_ext = {{CNT_W{1'b0}}, count_o};

   sqc_adder #(.SUM_W(SQ_W), .USE_RIPPLE(USE_RIPPLE)) u_adder (
      .a_i  (square_q),
      .b_i  (count_ext),
      .sum_o(sum)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         square_q <= '0;
      end else if (accept && at_max) begin
         square_q <= '0;
      end else if (accept || settle) begin
         square_q <= sum;
      end
   end

   assign square_o = square_q;

   // R1: reset state
   a_r1_reset: assert property (@(posedge clk)
      rst |=> (count_o == '0 && square_o == '0 && !wrap_o && ready_o));
   // R3: first addition uses the old count
   a_r3_partial: assert property (@(posedge clk) disable iff (rst)
      (accept && !at_max) |=> (square_o == $past(square_o) + $past(count_ext)));
   // R5: consistent whenever idle
   a_r5_square_done: assert property (@(posedge clk) disable iff (rst)
      settle |=> (square_o == count_ext * count_ext));
   // R6: no request, no change
   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (ready_o && !inc_req_i) |=> ($stable(count_o) && $stable(square_o)));
endmodule

// File: tb/run_square_counter_bench.sv
module run_square_counter_bench;
   localparam int W  = 8;
   localparam int SW = 2 * W;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          inc_req_i = 1'b0;
   logic          ready_o;
   logic [W-1:0]  count_o;
   logic [SW-1:0] square_o;
   logic          wrap_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   run_square_counter #(.CNT_W(W)) u_run_square_counter (
      .clk      (clk),
      .rst      (rst),
      .inc_req_i(inc_req_i),
      .ready_o  (ready_o),
      .count_o  (count_o),
      .square_o (square_o),
      .wrap_o   (wrap_o)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One increment; n_old is the model's count before the request.
   task automatic do_inc(input int n_old, input bit hold_req);
      int n_new;
      longint mid_sq;
      n_new  = (n_old + 1) % (1 << W);
      mid_sq = (n_new == 0) ? 0 : longint'(n_old) * n_old + n_old;
      @(negedge clk);
      inc_req_i = 1'b1;
      @(negedge clk);
      chk("R4 ready low after accept", ready_o, 0);
      chk("R2 count stepped", count_o, n_new);
      if (n_new == 0) begin
         chk("R7 square cleared on wrap", square_o, 0);
         chk("R7 wrap flag set", wrap_o, 1);
      end else begin
         chk("R3 partial square", square_o, mid_sq);
      end
      inc_req_i = hold_req;
      @(negedge clk);
      inc_req_i = 1'b0;
      chk("R4 ready back", ready_o, 1);
      chk("R4 held request ignored", count_o, n_new);
      chk("R5 square matches", square_o, longint'(n_new) * n_new);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R1 count reset", count_o, 0);
      chk("R1 square reset", square_o, 0);
      chk("R1 wrap reset", wrap_o, 0);
      chk("R1 ready reset", ready_o, 1);

      repeat (3) @(negedge clk);
      chk("R6 count holds", count_o, 0);
      chk("R6 square holds", square_o, 0);

      // Full sweep up to the top value.
      for (int n = 0; n < (1 << W) - 1; n++) begin
         do_inc(n, (n % 3) == 1);
         chk("R7 no early wrap", wrap_o, 0);
      end

      repeat (2) @(negedge clk);
      chk("R6 top count holds", count_o, (1 << W) - 1);
      chk("R6 top square holds", square_o, longint'((1 << W) - 1) * ((1 << W) - 1));

      do_inc((1 << W) - 1, 1'b0);

      for (int n = 0; n < 5; n++) begin
         do_inc(n, 1'b1);
         chk("R8 counts after wrap", count_o, n + 1);
         chk("R7 wrap sticky", wrap_o, 1);
      end

      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 count cleared again", count_o, 0);
      chk("R1 square cleared again", square_o, 0);
      chk("R1 wrap cleared again", wrap_o, 0);

      do_inc(0, 1'b0);
      do_inc(1, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule